// File: doc/BRIEF.md
# Periodic Receive Lock Recovery Scanner

This block watches the receive clock-recovery lock of a group of serial lanes and brings a lane back when its lock is lost. A period timer runs while the scanner is idle. When the timer expires, one scan starts. The scan walks the lanes one at a time from the lowest index to the highest. A lane that is not both initialized and powered up is passed over. A lane that is still locked is left alone. A lane that has lost lock gets a receive reset request. The request stays up until the lane reports that its reset is done, and only then does the scan move on.

Another agent, such as a software configuration path, may hold a lane. The scanner never acts on a held lane. It parks on that lane until the lane is released. The period timer starts counting again only once the whole scan has finished, so the gap between scans is one full period no matter how long a scan lasts. An enable input gates the block. Each lane has a saturating count of the resets issued to it.

Top module: `cdr_scan_watchdog`

The controller has three states:
- SCAN_IDLE: the timer runs.
- SCAN_PROBE: one lane is evaluated.
- SCAN_RECOVER: a reset request is held while the block waits for done.

The transitions are:
- SCAN_IDLE to SCAN_PROBE on timer expiry, starting at lane 0.
- SCAN_PROBE stays in SCAN_PROBE while the lane is held by another agent.
- SCAN_PROBE to SCAN_PROBE on the next lane when the lane is skipped or locked.
- SCAN_PROBE to SCAN_RECOVER when the lane is unlocked and free.
- SCAN_RECOVER to SCAN_PROBE on the next lane when done is seen.
- SCAN_PROBE or SCAN_RECOVER back to SCAN_IDLE after the last lane, or when enable is low as a lane completes.

## Requirements
- R1: After reset, no request is asserted and every recovery count is zero. With enable high, a scan begins PERIOD_CYC cycles after reset is released.
- R2: Lanes are visited in ascending index order, and at most one request bit is high at any time.
- R3: A lane whose initialized or powered-up flag is 0 is passed over in one cycle. It gets no request and its count does not change.
- R4: A lane that is active and locked gets no request. For the first active unlocked lane f, the request rises PERIOD_CYC+f+1 cycles after reset release, provided every lane below f is skipped or locked.
- R5: A request stays high until the matching done input is seen high at a clock edge. It drops at that edge, and the scan then continues with the next lane.
- R6: The next scan begins PERIOD_CYC cycles after the previous scan ends. With all lanes active and one unlocked lane, the gap between two consecutive request rises is PERIOD_CYC+NUM_LANES+L, where L is the number of cycles the request was held.
- R7: While the visited active lane is held (busy=1), no request is issued to it. The request rises one cycle after busy is seen low.
- R8: If enable is low when a lane completes, the scan stops there. No further lanes are visited and no new scan starts while enable stays low.
- R9: Each lane's recovery count increments by one for each request issued to that lane, and it saturates at 2^CNT_W-1.
- R10: Lane i's count sits at bits [i*CNT_W +: CNT_W] of recov_cnt. Lane i's request is bit i of rx_rst_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Scanner enable |
| lane_init | input | NUM_LANES | Per-lane initialized flag |
| lane_pwr | input | NUM_LANES | Per-lane powered-up flag |
| lane_locked | input | NUM_LANES | Per-lane receive lock status |
| lane_busy | input | NUM_LANES | Per-lane held-by-another-agent flag |
| rst_done | input | NUM_LANES | Per-lane receive reset completion |
| rx_rst_req | output | NUM_LANES | Per-lane receive reset request |
| recov_cnt | output | NUM_LANES*CNT_W | Packed per-lane saturating recovery counts |

## Verification
Every result has a due cycle counted from reset release or from a known event:
- The first request is due at PERIOD_CYC+f+1.
- A busy-delayed request is due one cycle after busy falls.
- A request falls exactly L cycles after it rises.
- Consecutive rises are PERIOD_CYC+NUM_LANES+L apart.

The bench timestamps each request edge at the falling clock edge and compares those stamps with the expected cycles. It reads the counts at a fixed point after a scan completes and before the next scan can begin.

// File: rtl/cdrwd_pkg.sv
package cdrwd_pkg;
    typedef enum logic [1:0] {
        SCAN_IDLE    = 2'd0,
        SCAN_PROBE   = 2'd1,
        SCAN_RECOVER = 2'd2
    } scan_state_t;
endpackage

// File: rtl/cdrwd_period_timer.sv
module cdrwd_period_timer #(
    parameter int PERIOD_CYC = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(PERIOD_CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R6
    AST_TIMER_IDLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt <= TW'(1)); // R6
endmodule

// File: rtl/cdrwd_sat_counter.sv
module cdrwd_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= '0;
        else if (bump && value != TOP)
            value <= value + 1'b1;
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        value == TOP |=> value == TOP); // R9
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(value)); // R9
endmodule

// File: rtl/cdr_scan_watchdog.sv
module cdr_scan_watchdog
    import cdrwd_pkg::*;
#(
    parameter int NUM_LANES  = 8,
    parameter int PERIOD_CYC = 250_000_000,
    parameter int CNT_W      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic [NUM_LANES-1:0]       lane_init,
    input  logic [NUM_LANES-1:0]       lane_pwr,
    input  logic [NUM_LANES-1:0]       lane_locked,
    input  logic [NUM_LANES-1:0]       lane_busy,
    input  logic [NUM_LANES-1:0]       rst_done,
    output logic [NUM_LANES-1:0]       rx_rst_req,
    output logic [NUM_LANES*CNT_W-1:0] recov_cnt
);
    localparam int IW = $clog2(NUM_LANES);
    localparam logic [IW-1:0] LAST_LANE = IW'(NUM_LANES - 1);

    scan_state_t          state, state_n;
    logic [IW-1:0]        lane_idx, lane_idx_n;
    logic [NUM_LANES-1:0] bump;
    logic                 tick, advance, lane_active;

    cdrwd_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == SCAN_IDLE && enable),
        .expire (tick)
    );

    assign lane_active = lane_init[lane_idx] & lane_pwr[lane_idx];

    always_comb begin
        state_n    = state;
        lane_idx_n = lane_idx;
        bump       = '0;
        advance    = 1'b0;
        unique case (state)
            SCAN_IDLE: begin
                if (tick) begin
                    state_n    = SCAN_PROBE;
                    lane_idx_n = '0;
                end
            end
            SCAN_PROBE: begin
                if (!lane_active)
                    advance = 1'b1;
                else if (lane_busy[lane_idx])
                    advance = 1'b0;
                else if (lane_locked[lane_idx])
                    advance = 1'b1;
                else begin
                    state_n        = SCAN_RECOVER;
                    bump[lane_idx] = 1'b1;
                end
            end
            SCAN_RECOVER: begin
                if (rst_done[lane_idx])
                    advance = 1'b1;
            end
            default: state_n = SCAN_IDLE;
        endcase
        if (advance) begin
            if (lane_idx == LAST_LANE || !enable) begin
                state_n    = SCAN_IDLE;
                lane_idx_n = '0;
            end else begin
                state_n    = SCAN_PROBE;
                lane_idx_n = lane_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SCAN_IDLE;
            lane_idx <= '0;
        end else begin
            state    <= state_n;
            lane_idx <= lane_idx_n;
        end
    end

    always_comb begin
        rx_rst_req = '0;
        if (state == SCAN_RECOVER)
            rx_rst_req[lane_idx] = 1'b1;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_cnt
        cdrwd_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .bump  (bump[g]),
            .value (recov_cnt[g*CNT_W +: CNT_W])
        );
    end

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_rst_req)); // R2
    AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        |(rx_rst_req & ~$past(rx_rst_req)) |->
            ((rx_rst_req & $past(lane_busy)) == '0)); // R7
    AST_REQ_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        |(rx_rst_req & ~$past(rx_rst_req)) |->
            ((rx_rst_req & ~($past(lane_init) & $past(lane_pwr) & ~$past(lane_locked))) == '0)); // R3
    AST_HOLD_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        |($past(rx_rst_req) & ~rx_rst_req) |-> |($past(rx_rst_req) & $past(rst_done))); // R5
endmodule

// File: tb/test_cdr_scan_watchdog.sv
module test_cdr_scan_watchdog;
    localparam int N   = 8;
    localparam int P   = 64;
    localparam int CW  = 2;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [N-1:0] lane_init = '0, lane_pwr = '0, lane_locked = '1, lane_busy = '0, rst_done = '0;
    logic [N-1:0] rx_rst_req;
    logic [N*CW-1:0] recov_cnt;

    int checks = 0, fails = 0;
    int cyc = 0, t0 = 0, resp_lat = 2, resp_cnt = 0, n_rise = 0, n_fall = 0;
    int rise_lane [64];
    int rise_t [64];
    int fall_t [64];
    logic [N-1:0] prev_req = '0;

    always #2 clk = ~clk;

    cdr_scan_watchdog #(.NUM_LANES(N), .PERIOD_CYC(P), .CNT_W(CW)) i_cdr_scan_watchdog (
        .clk(clk), .rst_n(rst_n), .enable(enable), .lane_init(lane_init),
        .lane_pwr(lane_pwr), .lane_locked(lane_locked), .lane_busy(lane_busy),
        .rst_done(rst_done), .rx_rst_req(rx_rst_req), .recov_cnt(recov_cnt)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int l = 0; l < N; l++) begin
            if (rx_rst_req[l] && !prev_req[l] && n_rise < 64) begin
                rise_lane[n_rise] = l;
                rise_t[n_rise] = cyc - t0;
                n_rise++;
            end
            if (!rx_rst_req[l] && prev_req[l] && n_fall < 64) begin
                fall_t[n_fall] = cyc - t0;
                n_fall++;
            end
        end
        prev_req = rx_rst_req;
        if (|rx_rst_req) resp_cnt++; else resp_cnt = 0;
        rst_done = (resp_cnt >= resp_lat) ? rx_rst_req : '0;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cnt_of(input int l);
        return int'(recov_cnt[l*CW +: CW]);
    endfunction

    task automatic start(input logic [N-1:0] ini, input logic [N-1:0] pw,
                         input logic [N-1:0] lk, input logic [N-1:0] bz);
        @(negedge clk);
        rst_n = 1'b0;
        enable = 1'b1;
        lane_init = ini; lane_pwr = pw; lane_locked = lk; lane_busy = bz;
        repeat (2) @(negedge clk);
        n_rise = 0; n_fall = 0; prev_req = '0;
        t0 = cyc;
        rst_n = 1'b1;
    endtask

    task automatic wait_rel(input int rel);
        while (cyc - t0 < rel) @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        start('1, '1, '1, '0);
        wait_rel(1);
        check(rx_rst_req == '0, "R1 no request after reset", int'(rx_rst_req), 0);
        check(recov_cnt == '0, "R1 counts zero after reset", int'(recov_cnt), 0);

        // R3 R4 R10 R2: sweep of eligibility patterns, one scan each
        for (int s = 0; s < 8; s++) begin
            logic [N-1:0] ini, pw, lk, elig;
            int first, pop;
            ini = ~(8'h01 << s) | 8'(s & 1);
            pw  = ~(8'h80 >> ((s * 3) % 8));
            lk  = 8'(s * 37 + 5) ^ 8'h5A;
            elig = ini & pw & ~lk;
            first = -1; pop = 0;
            for (int l = N - 1; l >= 0; l--) if (elig[l]) begin first = l; pop++; end
            start(ini, pw, lk, '0);
            wait_rel(P + 40);
            for (int l = 0; l < N; l++)
                check(cnt_of(l) == int'(elig[l]), "R3 R10 per-lane count after one scan", cnt_of(l), int'(elig[l]));
            check(n_rise == pop, "R4 number of requests in scan", n_rise, pop);
            if (first >= 0 && n_rise > 0)
                check(rise_t[0] == P + first + 1, "R4 first request cycle", rise_t[0], P + first + 1);
            for (int k = 1; k < n_rise; k++)
                check(rise_lane[k] > rise_lane[k-1], "R2 ascending lane order", rise_lane[k], rise_lane[k-1] + 1);
        end

        // R5 R6: one unlocked lane, two hold latencies
        for (int v = 0; v < 2; v++) begin
            resp_lat = (v == 0) ? 2 : 6;
            start('1, '1, ~(8'h01 << (5 - 3 * v)), '0);
            wait_rel(2 * P + 60);
            check(n_rise >= 2, "R6 two scans observed", n_rise, 2);
            if (n_rise >= 2 && n_fall >= 1) begin
                check(fall_t[0] - rise_t[0] == resp_lat, "R5 request held until done", fall_t[0] - rise_t[0], resp_lat);
                check(rise_t[1] - rise_t[0] == P + N + resp_lat, "R6 gap between scans", rise_t[1] - rise_t[0], P + N + resp_lat);
                check(rise_lane[0] == 5 - 3 * v, "R10 request bit position", rise_lane[0], 5 - 3 * v);
            end
        end
        resp_lat = 2;

        // R7 busy lane
        start('1, '1, ~8'h08, 8'h08);
        wait_rel(P + 12);
        check(rx_rst_req == '0, "R7 no request while busy", int'(rx_rst_req), 0);
        check(cnt_of(3) == 0, "R7 count unchanged while busy", cnt_of(3), 0);
        lane_busy = '0;
        begin
            int rel_free;
            rel_free = cyc - t0;
            wait_rel(rel_free + 3);
            check(n_rise == 1 && rise_t[0] == rel_free + 1, "R7 request one cycle after release", rise_t[0], rel_free + 1);
        end

        // R8 enable drop mid-scan
        start('1, '1, '0, '0);
        while (!rx_rst_req[2]) @(negedge clk);
        enable = 1'b0;
        repeat (3 * P) @(negedge clk);
        check(n_rise == 3, "R8 scan stops after current lane", n_rise, 3);
        for (int l = 0; l < N; l++)
            check(cnt_of(l) == ((l <= 2) ? 1 : 0), "R8 counts after stop", cnt_of(l), (l <= 2) ? 1 : 0);

        // R9 saturation
        start('1, '1, '0, '0);
        wait_rel(6 * (P + 3 * N + 4));
        for (int l = 0; l < N; l++)
            check(cnt_of(l) == MAXC, "R9 count saturates", cnt_of(l), MAXC);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule